// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor

This block adds or subtracts two W-bit two's-complement operands in a single combinational pass through a chain of full-adder cells. One select input picks the operation. For a subtraction the unit inverts every bit of the second operand and forces the carry into the lowest cell to one, so the same chain serves both operations. The outputs are the W-bit result, the raw carry out of the top cell, and a signed overflow flag.

The overflow flag is taken from the signs of the two effective addends and the sign of the result. The carry out plays no part in it. The carry out is still brought out for unsigned use. On an addition it marks an unsigned carry. On a subtraction a 1 means no borrow was needed, that is X >= Y as unsigned numbers.

The operand pair travels on a valid/ready stream and the result leaves on a second one. The block holds no storage, so the two handshakes are tied straight through:
- out_valid follows in_valid in the same cycle.
- in_ready follows out_ready.
- A stalled consumer stalls the producer in the same cycle, and a transfer happens on both sides at once.

The package also provides two helper functions, one that widens a value by copying its sign bit and one that negates a value in two's complement.

Top module: `addsub_unit`

## Requirements
- R1: With op_sub = 0, res equals (opnd_x + opnd_y) modulo 2^W.
- R2: With op_sub = 1, res equals (opnd_x - opnd_y) modulo 2^W. This is formed as opnd_x + ~opnd_y + 1; for example, 0101 - 0010 gives 0011 in the low bits.
- R3: When the two effective addends have different sign bits, ovf is 0 whatever the carry out. In 5 bits, 9 + (-7) gives 00010 with carry_out = 1 and ovf = 0.
- R4: ovf is 1 exactly when the effective addends share a sign and the result sign differs, which is when the true signed result lies outside [-2^(W-1), 2^(W-1)-1]. In 5 bits, 9 + 7 gives 10000 with carry_out 0 and ovf 1, and -9 + -9 gives 01110 with carry_out 1 and ovf 1.
- R5: carry_out is bit W of the unsigned sum opnd_x + effective Y + carry-in. On a subtraction it is 1 exactly when opnd_x >= opnd_y as unsigned numbers.
- R6: On a subtraction the overflow decision uses the sign of the complemented opnd_y, not the raw one:
  - In 5 bits, 11111 - 10000 gives 01111 with ovf 0.
  - 00000 - 10000 gives 10000 with ovf 1.
  - 10000 - 10000 gives 00000 with ovf 0.
- R7: out_valid equals in_valid and in_ready equals out_ready in the same cycle. With in_valid low, out_valid is low.
- R8: The package function sign_widen(v, n) copies bit n-1 of v into every higher bit. Applied to 8-bit -5 (11111011), it gives 16'hFFFB in the low 16 bits.
- R9: The package function twos_negate(v) returns ~v + 1. For v = 2 the low 32 bits are 32'hFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take the operand pair (follows out_ready) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opnd_x | input | W | First operand |
| opnd_y | input | W | Second operand |
| out_valid | output | 1 | Result is present (follows in_valid) |
| out_ready | input | 1 | Consumer takes the result |
| res | output | W | Sum or difference modulo 2^W |
| carry_out | output | 1 | Carry out of the top cell (on subtraction, 1 = no borrow) |
| ovf | output | 1 | Signed overflow |

## Verification
Carry out and signed overflow are separate functions, and both can be set by the same operand pair. The bench provokes them together with -9 + -9 in a 5-bit instance, where both must read 1. It also provokes each one alone:
- 9 + 7 gives overflow with no carry.
- 9 + (-7) gives a carry with no overflow.

This shows that neither flag is derived from the other. The 32-bit instance is then judged against a 64-bit signed reference and an unsigned compare. The operands are random values mixed with the most-negative and most-positive values.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // Widen: bit n-1 of v is copied into every position at or above n.
  function automatic logic [63:0] sign_widen(input logic [63:0] v, input int unsigned from_w);
    logic [63:0] w;
    int unsigned top;
    top = (from_w == 0) ? 0 : from_w - 1;
    for (int i = 0; i < 64; i++) begin
      w[i] = (i < int'(from_w)) ? v[i] : v[top];
    end
    return w;
  endfunction

  // Two's-complement negation: invert, then add one.
  function automatic logic [63:0] twos_negate(input logic [63:0] v);
    return ~v + 64'd1;
  endfunction

endpackage

// File: rtl/fa_cell.sv
`timescale 1ns/1ps
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a | b));
  end
endmodule

// File: rtl/operand_cond.sv
`timescale 1ns/1ps
module operand_cond #(
  parameter int W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] y_eff,
  output logic         cin
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_inv
      assign y_eff[i] = y_in[i] ^ sub;
    end
  endgenerate
  assign cin = sub;
endmodule

// File: rtl/carry_chain.sv
`timescale 1ns/1ps
module carry_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      fa_cell u_fa (
        .a  (a[i]),
        .b  (b[i]),
        .ci (c[i]),
        .s  (sum[i]),
        .co (c[i+1])
      );
    end
  endgenerate

  assign cout = c[W];
endmodule

// File: rtl/sign_ovf.sv
`timescale 1ns/1ps
module sign_ovf (
  input  logic sign_a,
  input  logic sign_b,
  input  logic sign_r,
  output logic ovf
);
  logic same_in;
  always_comb begin
    same_in = ~(sign_a ^ sign_b);
    ovf     = same_in & (sign_r ^ sign_a);
  end
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit #(
  parameter int W = 32
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         op_sub,
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res,
  output logic         carry_out,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_eff;
  logic         cin;
  logic [W-1:0] sum;

  operand_cond #(.W(W)) u_cond (
    .sub   (op_sub),
    .y_in  (opnd_y),
    .y_eff (y_eff),
    .cin   (cin)
  );

  carry_chain #(.W(W)) u_chain (
    .a    (opnd_x),
    .b    (y_eff),
    .cin  (cin),
    .sum  (sum),
    .cout (carry_out)
  );

  sign_ovf u_ovf (
    .sign_a (opnd_x[MSB]),
    .sign_b (y_eff[MSB]),
    .sign_r (sum[MSB]),
    .ovf    (ovf)
  );

  assign res       = sum;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/addsub_unit_chk.sv
`timescale 1ns/1ps
module addsub_unit_chk #(
  parameter int W = 32
) (
  input logic         op_sub,
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [W-1:0] res,
  input logic         carry_out,
  input logic         ovf
);
  logic [W:0]          u_sum;
  logic signed [W+1:0] sx, sy, s_wide;
  logic                in_range;
  logic                eff_sign_y;

  always_comb begin
    u_sum      = {1'b0, opnd_x} + {1'b0, (op_sub ? ~opnd_y : opnd_y)} + {{W{1'b0}}, op_sub};
    sx         = {{2{opnd_x[W-1]}}, opnd_x};
    sy         = {{2{opnd_y[W-1]}}, opnd_y};
    s_wide     = op_sub ? (sx - sy) : (sx + sy);
    in_range   = (s_wide[W+1] == s_wide[W]) && (s_wide[W] == s_wide[W-1]);
    eff_sign_y = op_sub ? ~opnd_y[W-1] : opnd_y[W-1];

    if (!op_sub) begin
      AST_ADD_RESULT: assert (res == opnd_x + opnd_y) else $error("add result mismatch"); // R1
    end else begin
      AST_SUB_RESULT: assert (res == opnd_x - opnd_y) else $error("sub result mismatch"); // R2
    end
    if (opnd_x[W-1] != eff_sign_y) begin
      AST_NO_OVERFLOW: assert (!ovf) else $error("overflow with opposite signs"); // R3
    end
    AST_OVF_RANGE: assert (ovf == !in_range) else $error("overflow vs range"); // R4
    AST_CARRY_OUT: assert (carry_out == u_sum[W]) else $error("carry mismatch"); // R5
  end
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) u_chk (
  .op_sub    (op_sub),
  .opnd_x    (opnd_x),
  .opnd_y    (opnd_y),
  .res       (res),
  .carry_out (carry_out),
  .ovf       (ovf)
);

// File: tb/addsub_unit_tb.sv
`timescale 1ns/1ps
module addsub_unit_tb;
  import addsub_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  logic        in_valid, op_sub, out_ready;
  logic [31:0] x, y;
  logic        in_ready, out_valid, carry_out, ovf;
  logic [31:0] res;

  logic        v5, sub5;
  logic [4:0]  x5, y5, res5;
  logic        rdy5, ov5, c5, ovf5;

  addsub_unit #(.W(32)) u_dut (
    .in_valid (in_valid), .in_ready (in_ready), .op_sub (op_sub),
    .opnd_x (x), .opnd_y (y), .out_valid (out_valid), .out_ready (out_ready),
    .res (res), .carry_out (carry_out), .ovf (ovf)
  );

  addsub_unit #(.W(5)) u_dut5 (
    .in_valid (v5), .in_ready (rdy5), .op_sub (sub5),
    .opnd_x (x5), .opnd_y (y5), .out_valid (ov5), .out_ready (1'b1),
    .res (res5), .carry_out (c5), .ovf (ovf5)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: {ovf, carry, res} from 64-bit signed math and an unsigned compare.
  function automatic logic [33:0] ref32(input logic [31:0] a, input logic [31:0] b, input logic s);
    longint sa, sb, sr;
    logic [63:0] ua, ub, usum;
    logic o, c;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sr = s ? (sa - sb) : (sa + sb);
    o  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    ua = {32'd0, a};
    ub = {32'd0, b};
    usum = ua + ub;
    c  = s ? (ua >= ub) : (usum[32]);
    return {o, c, sr[31:0]};
  endfunction

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [33:0] e;
    logic opp;
    @(posedge clk);
    #1;
    x = a; y = b; op_sub = s; in_valid = 1'b1;
    @(negedge clk);
    e = ref32(a, b, s);
    opp = a[31] != (s ? ~b[31] : b[31]);
    check(s ? "R2" : "R1", "res", {32'd0, res}, {32'd0, e[31:0]});
    check("R5", "carry_out", {63'd0, carry_out}, {63'd0, e[32]});
    check(opp ? "R3" : "R4", "ovf", {63'd0, ovf}, {63'd0, e[33]});
  endtask

  task automatic run5(input string req, input logic [4:0] a, input logic [4:0] b, input logic s,
                      input logic [4:0] er, input logic ec, input logic eo);
    @(posedge clk);
    #1;
    x5 = a; y5 = b; sub5 = s; v5 = 1'b1;
    @(negedge clk);
    check(req, "res5", {59'd0, res5}, {59'd0, er});
    check(req, "carry5", {63'd0, c5}, {63'd0, ec});
    check(req, "ovf5", {63'd0, ovf5}, {63'd0, eo});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    logic rs;
    int unused;
    in_valid = 1'b0; out_ready = 1'b0; op_sub = 1'b0; x = '0; y = '0;
    v5 = 1'b0; sub5 = 1'b0; x5 = '0; y5 = '0;
    unused = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: idle state and handshake pass-through
    check("R7", "out_valid idle", {63'd0, out_valid}, 64'd0);
    check("R7", "in_ready stalled", {63'd0, in_ready}, 64'd0);
    @(posedge clk); #1; out_ready = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R7", "out_valid", {63'd0, out_valid}, 64'd1);
    check("R7", "in_ready", {63'd0, in_ready}, 64'd1);

    // 5-bit directed cases
    run5("R4", 5'b01001, 5'b00111, 1'b0, 5'b10000, 1'b0, 1'b1);
    run5("R4", 5'b10111, 5'b10111, 1'b0, 5'b01110, 1'b1, 1'b1);
    run5("R3", 5'b01001, 5'b11001, 1'b0, 5'b00010, 1'b1, 1'b0);
    run5("R2", 5'b00101, 5'b00010, 1'b1, 5'b00011, 1'b1, 1'b0);
    run5("R6", 5'b11111, 5'b10000, 1'b1, 5'b01111, 1'b1, 1'b0);
    run5("R6", 5'b00000, 5'b10000, 1'b1, 5'b10000, 1'b0, 1'b1);
    run5("R6", 5'b10000, 5'b10000, 1'b1, 5'b00000, 1'b1, 1'b0);
    check("R7", "rdy5", {63'd0, rdy5}, 64'd1);
    check("R7", "ov5", {63'd0, ov5}, 64'd1);

    // 32-bit corners
    run32(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    run32(32'h8000_0000, 32'h0000_0001, 1'b1);
    run32(32'h8000_0000, 32'h8000_0000, 1'b0);
    run32(32'h0000_0000, 32'h8000_0000, 1'b1);
    run32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    run32(32'h0000_0005, 32'h0000_0002, 1'b1);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: ra = 32'h8000_0000;
        1: ra = 32'h7FFF_FFFF;
        2: ra = $urandom % 16;
        default: ra = $urandom;
      endcase
      rb = ($urandom % 3 == 0) ? 32'h8000_0000 : $urandom;
      rs = $urandom % 2;
      run32(ra, rb, rs);
    end

    // R8 / R9: package helpers
    check("R8", "sign_widen -5", {48'd0, sign_widen(64'h0000_0000_0000_00FB, 8)}[15:0] == 16'hFFFB ? 64'd1 : 64'd0, 64'd1);
    check("R8", "sign_widen +5", sign_widen(64'h0000_0000_0000_0005, 8), 64'd5);
    check("R9", "twos_negate 2", {32'd0, twos_negate(64'd2)}[31:0] == 32'hFFFF_FFFE ? 64'd1 : 64'd0, 64'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule